// File: doc/BRIEF.md
# Wake-up edge detection controller

This block serves one group of eight wake-up inputs on a microcontroller. Each external pin is brought into the local clock domain by a two-flop synchronizer. A transition is found by comparing the synchronized level with its value one clock earlier. When the transition matches the polarity chosen for that pin, a sticky status bit is set. Per pin, software picks rising or falling detection, or it sets a separate override bit so that the pin detects both edges. Status bits are cleared by writing ones to them.

A byte-wide register port reaches four registers, selected by a 2-bit address:

| Address | Register | Meaning of a 1 bit |
|---|---|---|
| 0 | polarity | the pin detects falling edges |
| 1 | status | an event has been latched for the pin |
| 2 | enable | the pin may raise the interrupt |
| 3 | dual-edge | the pin detects both edges |

The single interrupt output is high whenever a pin has its status bit set and is enabled. A build parameter decides whether the group implements the enable register. Without it, every pin counts as enabled, writes to address 2 do nothing, and reads of address 2 return all ones.

Top module: `wake_edge_ctrl`

## Requirements
- R1: After reset, the polarity, status, dual-edge and (if present) enable registers all read 0x00, and irq_o is 0.
- R2: A pin with polarity bit 0 and dual-edge bit 0 sets its status bit on a rising edge and ignores falling edges.
- R3: A pin with polarity bit 1 and dual-edge bit 0 sets its status bit on a falling edge and ignores rising edges.
- R4: A pin with dual-edge bit 1 sets its status bit on both rising and falling edges, whatever its polarity bit holds.
- R5: A write to address 1 clears each status bit whose data bit is 1 and leaves each status bit whose data bit is 0 unchanged.
- R6: If a pin's edge and a write of 1 to its status bit are taken on the same clock edge, the status bit ends up set.
- R7: Status bits are set whether or not the pin is enabled. irq_o is 1 exactly when some pin has both its status bit and its enable bit set.
- R8: With HAS_ENABLE=0, address 2 reads 0xFF, writes to it have no effect, and irq_o is 1 whenever any status bit is set.
- R9: A read strobe sampled on a clock edge places the addressed register on rdata_o from that edge on. rdata_o holds its value while rd_en_i is low. Polarity, dual-edge and enable read back what was written.
- R10: If a pin level is changed before clock edge k, so that edge k samples it first, the matching status bit (and irq_o, for an enabled pin) is set at edge k+2 and not earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pin_i | input | 8 | Asynchronous wake-up pins |
| addr_i | input | 2 | Register select: 0 polarity, 1 status, 2 enable, 3 dual-edge |
| wr_en_i | input | 1 | Write strobe |
| rd_en_i | input | 1 | Read strobe |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Registered read data |
| irq_o | output | 1 | Combined wake-up interrupt |

## Verification
A wrong synchronizer or edge-history state shows up as a status bit that is missing, extra, or set one cycle early or late. The irq_o output shows this directly on the third edge after a pin change, and a status read shows it one cycle later. A corrupted polarity or dual-edge bit shows up on the next edge of the opposite direction, as a wrong status readback. A lost set-over-clear case shows up as a cleared status bit, and as irq_o dropping, in the cycle right after the colliding write.

// File: rtl/wake_pkg.sv
package wake_pkg;
    typedef enum logic [1:0] {
        REG_POL  = 2'd0,
        REG_STAT = 2'd1,
        REG_ENAB = 2'd2,
        REG_DUAL = 2'd3
    } wake_reg_e;
endpackage

// File: rtl/wake_sync.sv
module wake_sync #(
    parameter int W = 8
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic [W-1:0] pin_i,
    output logic [W-1:0] cur_o,
    output logic [W-1:0] prev_o
);
    logic [W-1:0] meta_q;
    logic [W-1:0] cur_q;
    logic [W-1:0] prev_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            meta_q <= '0;
            cur_q  <= '0;
            prev_q <= '0;
        end else begin
            meta_q <= pin_i;
            cur_q  <= meta_q;
            prev_q <= cur_q;
        end
    end

    assign cur_o  = cur_q;
    assign prev_o = prev_q;
endmodule

// File: rtl/wake_edge_sel.sv
module wake_edge_sel #(
    parameter int W = 8
) (
    input  logic [W-1:0] cur_i,
    input  logic [W-1:0] prev_i,
    input  logic [W-1:0] pol_i,
    input  logic [W-1:0] dual_i,
    output logic [W-1:0] evt_o
);
    for (genvar g = 0; g < W; g++) begin : g_pin
        logic rise;
        logic fall;
        assign rise = cur_i[g] & ~prev_i[g];
        assign fall = ~cur_i[g] & prev_i[g];
        always_comb begin
            if (dual_i[g])     evt_o[g] = rise | fall;
            else if (pol_i[g]) evt_o[g] = fall;
            else               evt_o[g] = rise;
        end
    end
endmodule

// File: rtl/wake_regs.sv
module wake_regs
    import wake_pkg::*;
#(
    parameter int W          = 8,
    parameter bit HAS_ENABLE = 1'b1
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic [1:0]   addr_i,
    input  logic         wr_en_i,
    input  logic         rd_en_i,
    input  logic [W-1:0] wdata_i,
    input  logic [W-1:0] evt_i,
    output logic [W-1:0] rdata_o,
    output logic [W-1:0] pol_o,
    output logic [W-1:0] dual_o,
    output logic [W-1:0] status_o,
    output logic [W-1:0] enable_o
);
    wake_reg_e    sel;
    logic [W-1:0] pol_q;
    logic [W-1:0] dual_q;
    logic [W-1:0] stat_q;
    logic [W-1:0] stat_d;
    logic [W-1:0] clr_mask;
    logic [W-1:0] rdata_q;
    logic [W-1:0] rd_mux;

    assign sel = wake_reg_e'(addr_i);

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            pol_q  <= '0;
            dual_q <= '0;
        end else if (wr_en_i) begin
            if (sel == REG_POL)  pol_q  <= wdata_i;
            if (sel == REG_DUAL) dual_q <= wdata_i;
        end
    end

    // Write-one-to-clear; a fresh event overrides the clear (set wins).
    assign clr_mask = (wr_en_i && sel == REG_STAT) ? wdata_i : '0;
    assign stat_d   = (stat_q & ~clr_mask) | evt_i;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stat_q <= '0;
        else         stat_q <= stat_d;
    end

    if (HAS_ENABLE) begin : g_enab
        logic [W-1:0] enab_q;
        always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni)                          enab_q <= '0;
            else if (wr_en_i && sel == REG_ENAB)  enab_q <= wdata_i;
        end
        assign enable_o = enab_q;
    end else begin : g_no_enab
        assign enable_o = '1;
    end

    always_comb begin
        unique case (sel)
            REG_POL:  rd_mux = pol_q;
            REG_STAT: rd_mux = stat_q;
            REG_ENAB: rd_mux = enable_o;
            REG_DUAL: rd_mux = dual_q;
            default:  rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)      rdata_q <= '0;
        else if (rd_en_i) rdata_q <= rd_mux;
    end

    assign rdata_o  = rdata_q;
    assign pol_o    = pol_q;
    assign dual_o   = dual_q;
    assign status_o = stat_q;

    // R5: bits written with 1 and not hit by an event read 0 afterwards
    a_r5_w1c_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_en_i && sel == REG_STAT) |=> ((stat_q & $past(wdata_i & ~evt_i)) == '0));

    // R6: an event always leaves its status bit set, even under a clear
    a_r6_set_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (evt_i != '0) |=> ((stat_q & $past(evt_i)) == $past(evt_i)));

    // R2: a status bit only rises because an event was seen
    a_r2_rise_needs_event: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (stat_q != $past(stat_q)) |-> ((stat_q & ~$past(stat_q) & ~$past(evt_i)) == '0));

    // R9: read data holds while no read is strobed
    a_r9_rdata_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !rd_en_i |=> $stable(rdata_q));

    if (!HAS_ENABLE) begin : g_chk_noen
        // R8: the absent enable register reads all ones
        a_r8_absent_reads_ones: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (rd_en_i && sel == REG_ENAB) |=> (rdata_q == '1));
    end
endmodule

// File: rtl/wake_edge_ctrl.sv
module wake_edge_ctrl #(
    parameter int W          = 8,
    parameter bit HAS_ENABLE = 1'b1
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic [W-1:0] pin_i,
    input  logic [1:0]   addr_i,
    input  logic         wr_en_i,
    input  logic         rd_en_i,
    input  logic [W-1:0] wdata_i,
    output logic [W-1:0] rdata_o,
    output logic         irq_o
);
    logic [W-1:0] cur;
    logic [W-1:0] prev;
    logic [W-1:0] pol;
    logic [W-1:0] dual;
    logic [W-1:0] evt;
    logic [W-1:0] status;
    logic [W-1:0] enable;

    wake_sync #(.W(W)) u_sync (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .pin_i  (pin_i),
        .cur_o  (cur),
        .prev_o (prev)
    );

    wake_edge_sel #(.W(W)) u_edge (
        .cur_i  (cur),
        .prev_i (prev),
        .pol_i  (pol),
        .dual_i (dual),
        .evt_o  (evt)
    );

    wake_regs #(.W(W), .HAS_ENABLE(HAS_ENABLE)) u_regs (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .addr_i   (addr_i),
        .wr_en_i  (wr_en_i),
        .rd_en_i  (rd_en_i),
        .wdata_i  (wdata_i),
        .evt_i    (evt),
        .rdata_o  (rdata_o),
        .pol_o    (pol),
        .dual_o   (dual),
        .status_o (status),
        .enable_o (enable)
    );

    assign irq_o = |(status & enable);

    // R7: the interrupt never fires with no latched status
    a_r7_irq_needs_status: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (status == '0) |-> !irq_o);

    // R10: no event reaches status without a synchronized change
    a_r10_event_needs_change: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (evt != '0) |-> (cur != prev));
endmodule

// File: tb/wake_edge_ctrl_bench.sv
module wake_edge_ctrl_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] pins = 8'h00;
    logic [1:0] addr = 2'd0;
    logic       wr = 1'b0;
    logic       rd = 1'b0;
    logic [7:0] wdata = 8'h00;
    logic [7:0] rdata_a, rdata_b;
    logic       irq_a, irq_b;
    int         checks = 0;
    int         failures = 0;
    logic [7:0] ra, rb;

    always #4 clk = ~clk;

    wake_edge_ctrl #(.W(8), .HAS_ENABLE(1'b1)) u_wake_edge_ctrl (
        .clk_i(clk), .rst_ni(rst_n), .pin_i(pins), .addr_i(addr),
        .wr_en_i(wr), .rd_en_i(rd), .wdata_i(wdata),
        .rdata_o(rdata_a), .irq_o(irq_a));

    wake_edge_ctrl #(.W(8), .HAS_ENABLE(1'b0)) u_noen (
        .clk_i(clk), .rst_ni(rst_n), .pin_i(pins), .addr_i(addr),
        .wr_en_i(wr), .rd_en_i(rd), .wdata_i(wdata),
        .rdata_o(rdata_b), .irq_o(irq_b));

    function automatic logic [7:0] exp_evt(logic [7:0] o, logic [7:0] n,
                                          logic [7:0] pol, logic [7:0] dual);
        logic [7:0] r;
        for (int i = 0; i < 8; i++) begin
            logic rise, fall;
            rise = n[i] & ~o[i];
            fall = ~n[i] & o[i];
            r[i] = dual[i] ? (rise | fall) : (pol[i] ? fall : rise);
        end
        return r;
    endfunction

    task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wreg(logic [1:0] a, logic [7:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr = 1'b1;
        @(posedge clk);
        @(negedge clk);
        wr = 1'b0;
    endtask

    task automatic rreg(logic [1:0] a);
        @(negedge clk);
        addr = a; rd = 1'b1;
        @(posedge clk);
        @(negedge clk);
        rd = 1'b0;
        ra = rdata_a;
        rb = rdata_b;
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        #1_000_000;
        failures++;
        $display("FAIL watchdog actual=%h expected=%h", 8'h00, 8'h01);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [7:0] p, d, e, np, ex;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        check("R1 irq_a", {7'd0, irq_a}, 8'h00);
        check("R1 irq_b", {7'd0, irq_b}, 8'h00);
        for (int a = 0; a < 4; a++) begin
            rreg(2'(a));
            check("R1 read main", ra, 8'h00);
            check(a == 2 ? "R8 reset read absent enable" : "R1 read noen", rb,
                  a == 2 ? 8'hFF : 8'h00);
        end

        // R9 readback, R8 write to absent enable ignored
        wreg(2'd0, 8'hA5); wreg(2'd3, 8'h3C); wreg(2'd2, 8'h5A);
        rreg(2'd0); check("R9 polarity", ra, 8'hA5);
        rreg(2'd3); check("R9 dual", ra, 8'h3C);
        rreg(2'd2); check("R9 enable", ra, 8'h5A);
        check("R8 enable write ignored", rb, 8'hFF);
        addr = 2'd0; idle(3);
        check("R9 rdata holds", rdata_a, 8'h5A);

        wreg(2'd0, 8'h00); wreg(2'd3, 8'h00); wreg(2'd2, 8'hFF);

        // R10 latency, R2 rising
        @(negedge clk); pins = 8'h0F;
        @(negedge clk); check("R10 irq after edge k", {7'd0, irq_a}, 8'h00);
        @(negedge clk); check("R10 irq after edge k+1", {7'd0, irq_a}, 8'h00);
        @(negedge clk); check("R10 irq after edge k+2", {7'd0, irq_a}, 8'h01);
        rreg(2'd1); check("R2 rising sets status", ra, 8'h0F);
        wreg(2'd1, 8'hFF);
        @(negedge clk); pins = 8'h00; idle(4);
        rreg(2'd1); check("R2 falling ignored", ra, 8'h00);

        // R3 falling
        wreg(2'd0, 8'hFF);
        @(negedge clk); pins = 8'hF0; idle(4);
        rreg(2'd1); check("R3 rising ignored", ra, 8'h00);
        @(negedge clk); pins = 8'h00; idle(4);
        rreg(2'd1); check("R3 falling sets status", ra, 8'hF0);

        // R5 write-one-to-clear
        wreg(2'd1, 8'h30); rreg(2'd1); check("R5 partial clear", ra, 8'hC0);
        wreg(2'd1, 8'h00); rreg(2'd1); check("R5 zero write keeps", ra, 8'hC0);

        // R4 dual edge
        wreg(2'd1, 8'hFF); wreg(2'd3, 8'hFF); wreg(2'd0, 8'hAA);
        @(negedge clk); pins = 8'h55; idle(4);
        rreg(2'd1); check("R4 dual rising", ra, 8'h55);
        wreg(2'd1, 8'hFF);
        @(negedge clk); pins = 8'h00; idle(4);
        rreg(2'd1); check("R4 dual falling", ra, 8'h55);

        // R7 status without enable, irq gating; R8 irq without enable register
        wreg(2'd1, 8'hFF); wreg(2'd3, 8'h00); wreg(2'd0, 8'h00); wreg(2'd2, 8'h01);
        @(negedge clk); pins = 8'h02; idle(4);
        rreg(2'd1); check("R7 status set while disabled", ra, 8'h02);
        check("R7 irq low when disabled", {7'd0, irq_a}, 8'h00);
        check("R8 irq without enable register", {7'd0, irq_b}, 8'h01);
        wreg(2'd2, 8'h02);
        check("R7 irq after enabling", {7'd0, irq_a}, 8'h01);

        // R6 set wins over same-cycle clear; pin 1 set, pin 0 toggles in dual mode
        wreg(2'd3, 8'h01);
        @(negedge clk); pins = 8'h03; idle(4);
        wreg(2'd1, 8'h00);
        rreg(2'd1); check("R6 setup", ra, 8'h03);
        @(negedge clk); pins = 8'h02;
        @(negedge clk);
        @(negedge clk);
        addr = 2'd1; wdata = 8'hFF; wr = 1'b1;
        @(negedge clk); wr = 1'b0;
        rreg(2'd1); check("R6 set wins, other bit cleared", ra, 8'h01);

        // Random phase: R2 R3 R4 R7 R8
        void'($urandom(32'd1234));
        p = pins;
        for (int it = 0; it < 40; it++) begin
            logic [7:0] pol, dual, en;
            pol = 8'($urandom); dual = 8'($urandom); en = 8'($urandom);
            wreg(2'd0, pol); wreg(2'd3, dual); wreg(2'd2, en);
            wreg(2'd1, 8'hFF);
            np = 8'($urandom);
            @(negedge clk); pins = np; idle(4);
            ex = exp_evt(p, np, pol, dual);
            p = np;
            rreg(2'd1);
            check("R4 random status main", ra, ex);
            check("R8 random status noen", rb, ex);
            check("R7 random irq main", {7'd0, irq_a}, {7'd0, |(ex & en)});
            check("R8 random irq noen", {7'd0, irq_b}, {7'd0, |ex});
        end
        d = 8'h00; e = d;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule